// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a two-dimensional table of 2-bit saturating counters. A hash of the branch address picks the row. A shift register of recent branch directions picks the column. Each row therefore holds one counter for every possible history value. The front end presents a fetch address and gets a direction back in the same cycle. With the direction comes the history value that was used, which travels down the pipeline with the branch.

When the branch resolves, the back end returns the address, the real outcome and that history snapshot. The counter the prediction came from is then trained. Every predicted branch pushes its guessed direction into the speculative history. A misprediction may only be found after several younger branches have already been predicted. When one is reported, the history is rebuilt from the carried snapshot plus the real outcome, which discards every wrong-path shift in one step.

Top module: `bhp_two_level_predictor`

## Requirements
- R1: After reset every counter holds weakly not taken (2'b01), so every lookup returns not taken, and the speculative history reads all zeros.
- R2: In every cycle, whether or not `pred_valid` is high, `pred_taken` is bit 1 of the counter at row hash(`pred_pc`) and column `pred_hist`. It is combinational, with no cycle of latency.
- R3: Counter encoding is 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. A taken update adds one and stops at 11. A not-taken update subtracts one and stops at 00.
- R4: The row index is the XOR of consecutive ROW_W-bit slices of `pc[ADDR_W-1:ALIGN_W]`, with the top slice zero-padded. The ALIGN_W alignment bits have no effect. Addresses with the same fold share a row.
- R5: When `pred_valid` is high and no misprediction is reported in that cycle, the next history is {old history without its MSB, `pred_taken`}.
- R6: `pred_hist` shows the history that indexes the current lookup, so it is the snapshot to carry with the branch.
- R7: When `upd_valid` and `upd_mispredict` are both high, the next history is {`upd_hist` without its MSB, `upd_taken`}. This overrides any prediction shift in the same cycle.
- R8: Counters change only through updates. Predictions never train.
- R9: An update writes the counter at row hash(`upd_pc`) and column `upd_hist`. A lookup of that same entry in the same cycle returns the value from before the update.
- R10: The history holds its value in any cycle with no prediction and no misprediction report, including cycles with a correctly predicted update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_valid | input | 1 | A branch is predicted this cycle; its direction enters the history |
| pred_pc | input | ADDR_W | Fetch address to look up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History used by this lookup (snapshot to carry) |
| upd_valid | input | 1 | A resolved branch trains its counter |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | HIST_W | Snapshot carried from prediction time |
| upd_mispredict | input | 1 | The prediction was wrong; rewind the history |

## Verification
Directed runs drive one counter through all four states and hold it at both saturation ends, so an off-by-one or a wrap is caught. Other directed runs look up addresses that differ only in alignment bits, or that differ by bits which cancel in the fold, to separate a correct hash from a sliced or unfolded one. Same-cycle cases put an update on the entry being read, and a misprediction in the same cycle as a prediction, to check read-before-write and the priority of the rewind. A long random mix over a small address pool, with random snapshots and mispredictions, is checked cycle by cycle against a bench model of the table and history. A second reset at the end confirms that the trained state is discarded.

// File: rtl/bhp_pkg.sv
// Shared types and helpers for the two-level branch predictor.
// Assumes the 2-bit counter encoding 00 SNT, 01 WNT, 10 WT, 11 ST.
package bhp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_SNT = 2'b00;
    localparam ctr_t CTR_WNT = 2'b01;
    localparam ctr_t CTR_WT  = 2'b10;
    localparam ctr_t CTR_ST  = 2'b11;

    // Saturating step of one counter toward the resolved outcome
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken) begin
            nxt = (cur == CTR_ST) ? CTR_ST : cur + 2'd1;
        end else begin
            nxt = (cur == CTR_SNT) ? CTR_SNT : cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bhp_row_hash.sv
// Folds a branch address into a row index by XOR-ing ROW_W-bit slices
// of the address above the alignment bits; the top slice is zero-padded.
// Assumes ADDR_W > ALIGN_W. Purely combinational.
module bhp_row_hash #(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 2,
    parameter int ROW_W   = 4
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [ROW_W-1:0]  row
);
    localparam int FOLD_BITS = ADDR_W - ALIGN_W;
    localparam int N_SLICE   = (FOLD_BITS + ROW_W - 1) / ROW_W;
    localparam int PAD_BITS  = N_SLICE * ROW_W - FOLD_BITS;

    logic [N_SLICE*ROW_W-1:0] padded;
    logic [ROW_W-1:0]         partial [N_SLICE];
    logic                     unused_align;

    // Alignment bits carry no information about the branch
    assign unused_align = ^pc[ALIGN_W-1:0];

    generate
        if (PAD_BITS > 0) begin : g_pad
            assign padded = {{PAD_BITS{1'b0}}, pc[ADDR_W-1:ALIGN_W]};
        end else begin : g_nopad
            assign padded = pc[ADDR_W-1:ALIGN_W];
        end

        // Running XOR over the slices, one stage per slice
        for (genvar s = 0; s < N_SLICE; s++) begin : g_fold
            if (s == 0) begin : g_first
                assign partial[s] = padded[ROW_W-1:0];
            end else begin : g_next
                assign partial[s] = partial[s-1] ^ padded[s*ROW_W +: ROW_W];
            end
        end
    endgenerate

    assign row = partial[N_SLICE-1];

endmodule

// File: rtl/bhp_history.sv
// Speculative global history register. Shifts in each predicted direction;
// on a misprediction it is rebuilt from the carried snapshot plus the true
// outcome, which wins over a same-cycle shift. Assumes HIST_W >= 2.
module bhp_history #(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              restore_en,
    input  logic [HIST_W-1:0] restore_snap,
    input  logic              restore_bit,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;

    // History update: rewind first, else speculative shift, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (restore_en) begin
            hist_q <= {restore_snap[HIST_W-2:0], restore_bit};
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_W-2:0], shift_bit};
        end
    end

    assign hist = hist_q;

endmodule

// File: rtl/bhp_counter_table.sv
// Table of ROWS x 2^HIST_W 2-bit saturating counters, held in flops.
// One asynchronous read port and one read-modify-write port; a read of
// an entry being written returns the old value. Reset loads weakly not taken.
module bhp_counter_table
    import bhp_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [HIST_W-1:0] rd_col,
    output ctr_t              rd_ctr,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [HIST_W-1:0] wr_col,
    input  logic              wr_taken
);
    localparam int IDX_W   = ROW_W + HIST_W;
    localparam int ENTRIES = 1 << IDX_W;

    ctr_t             ctr_mem [ENTRIES];
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;

    assign rd_idx = {rd_row, rd_col};
    assign wr_idx = {wr_row, wr_col};

    // Lookup: combinational read of the selected counter
    assign rd_ctr = ctr_mem[rd_idx];

    // Training: reset fill, else saturating step of the addressed counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ctr_mem[i] <= CTR_WNT;
            end
        end else if (wr_en) begin
            ctr_mem[wr_idx] <= ctr_step(ctr_mem[wr_idx], wr_taken);
        end
    end

endmodule

// File: rtl/bhp_two_level_predictor.sv
// Two-level adaptive branch direction predictor. The hashed address picks a
// row and the speculative history picks a column. The lookup is same-cycle;
// training happens only at resolution using the carried snapshot.
// Assumes at most one prediction and one update per cycle.
module bhp_two_level_predictor
    import bhp_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 2,
    parameter int ROW_W   = 4,
    parameter int HIST_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid,
    input  logic [ADDR_W-1:0] pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_mispredict
);
    logic [ROW_W-1:0]  pred_row;
    logic [ROW_W-1:0]  upd_row;
    logic [HIST_W-1:0] spec_hist;
    ctr_t              look_ctr;
    logic              rewind;

    bhp_row_hash #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .ROW_W(ROW_W)) u_hash_pred (
        .pc  (pred_pc),
        .row (pred_row)
    );

    bhp_row_hash #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .ROW_W(ROW_W)) u_hash_upd (
        .pc  (upd_pc),
        .row (upd_row)
    );

    // A reported misprediction rewinds the speculative history
    assign rewind = upd_valid & upd_mispredict;

    bhp_history #(.HIST_W(HIST_W)) u_hist (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift_en     (pred_valid),
        .shift_bit    (pred_taken),
        .restore_en   (rewind),
        .restore_snap (upd_hist),
        .restore_bit  (upd_taken),
        .hist         (spec_hist)
    );

    bhp_counter_table #(.ROW_W(ROW_W), .HIST_W(HIST_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_row   (pred_row),
        .rd_col   (spec_hist),
        .rd_ctr   (look_ctr),
        .wr_en    (upd_valid),
        .wr_row   (upd_row),
        .wr_col   (upd_hist),
        .wr_taken (upd_taken)
    );

    // Direction is the counter MSB; the history used is exported as snapshot
    assign pred_taken = look_ctr[1];
    assign pred_hist  = spec_hist;

endmodule

// File: rtl/bhp_checker.sv
// Port-level temporal checks on the predictor's history behaviour.
// Bound to every instance of the top module.
module bhp_checker #(
    parameter int HIST_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pred_valid,
    input logic              pred_taken,
    input logic [HIST_W-1:0] pred_hist,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIST_W-1:0] upd_hist,
    input logic              upd_mispredict
);
    // R5: a prediction without a rewind shifts its direction in
    a_r5_spec_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !(upd_valid && upd_mispredict))
        |=> pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(pred_taken)});

    // R7: a misprediction rebuilds history from snapshot and outcome
    a_r7_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_mispredict)
        |=> pred_hist == {$past(upd_hist[HIST_W-2:0]), $past(upd_taken)});

    // R10: history holds when nothing shifts or rewinds it
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_valid && !(upd_valid && upd_mispredict)) |=> $stable(pred_hist));

    // R2: the lookup always yields a known direction
    a_r2_known_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(pred_taken));

    // R6: the exported snapshot is never unknown
    a_r6_known_snap: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(pred_hist));

endmodule

bind bhp_two_level_predictor bhp_checker #(.HIST_W(HIST_W)) u_bhp_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .pred_valid     (pred_valid),
    .pred_taken     (pred_taken),
    .pred_hist      (pred_hist),
    .upd_valid      (upd_valid),
    .upd_taken      (upd_taken),
    .upd_hist       (upd_hist),
    .upd_mispredict (upd_mispredict)
);

// File: tb/bhp_two_level_predictor_tb.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared against a bench model of the counter table and history.
module bhp_two_level_predictor_tb;
    localparam int ADDR_W  = 32;
    localparam int ALIGN_W = 2;
    localparam int ROW_W   = 4;
    localparam int HIST_W  = 4;
    localparam int ENTRIES = 1 << (ROW_W + HIST_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pred_valid = 1'b0;
    logic [ADDR_W-1:0] pred_pc = '0;
    logic              pred_taken;
    logic [HIST_W-1:0] pred_hist;
    logic              upd_valid = 1'b0;
    logic [ADDR_W-1:0] upd_pc = '0;
    logic              upd_taken = 1'b0;
    logic [HIST_W-1:0] upd_hist = '0;
    logic              upd_mispredict = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [1:0]        m_ctr [ENTRIES];
    logic [HIST_W-1:0] m_hist;

    always #5 clk = ~clk;

    bhp_two_level_predictor #(
        .ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .ROW_W(ROW_W), .HIST_W(HIST_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pred_valid(pred_valid), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_hist(pred_hist),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_hist(upd_hist), .upd_mispredict(upd_mispredict)
    );

    // Row hash as stated in R4: XOR of ROW_W slices above the alignment bits
    function automatic int row_of(input logic [ADDR_W-1:0] pc);
        logic [ROW_W-1:0] acc = '0;
        for (int b = ALIGN_W; b < ADDR_W; b++) begin
            acc[(b - ALIGN_W) % ROW_W] ^= pc[b];
        end
        return int'(acc);
    endfunction

    function automatic int idx_of(input logic [ADDR_W-1:0] pc, input logic [HIST_W-1:0] h);
        return row_of(pc) * (1 << HIST_W) + int'(h);
    endfunction

    function automatic logic [1:0] m_step(input logic [1:0] c, input logic t);
        if (t) return (c == 2'b11) ? 2'b11 : c + 2'd1;
        return (c == 2'b00) ? 2'b00 : c - 2'd1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < ENTRIES; i++) m_ctr[i] = 2'b01;
        m_hist = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pred_valid = 1'b0; upd_valid = 1'b0; upd_mispredict = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // One cycle: drive at negedge, check outputs, then advance model past posedge
    task automatic cycle(input string tag, input logic pv, input logic [ADDR_W-1:0] ppc,
                         input logic uv, input logic [ADDR_W-1:0] upc, input logic ut,
                         input logic [HIST_W-1:0] uh, input logic um);
        logic exp_t;
        @(negedge clk);
        pred_valid = pv; pred_pc = ppc; upd_valid = uv; upd_pc = upc;
        upd_taken = ut; upd_hist = uh; upd_mispredict = um;
        #1;
        exp_t = m_ctr[idx_of(ppc, m_hist)][1];
        n_tests++;
        if (pred_hist !== m_hist) begin
            n_fail++;
            $display("FAIL %s history: got %b expected %b", tag, pred_hist, m_hist);
        end
        n_tests++;
        if (pred_taken !== exp_t) begin
            n_fail++;
            $display("FAIL %s direction pc=%h: got %b expected %b", tag, ppc, pred_taken, exp_t);
        end
        @(posedge clk);
        if (uv) m_ctr[idx_of(upc, uh)] = m_step(m_ctr[idx_of(upc, uh)], ut);
        if (uv && um) m_hist = {uh[HIST_W-2:0], ut};
        else if (pv) m_hist = {m_hist[HIST_W-2:0], exp_t};
    endtask

    localparam logic [ADDR_W-1:0] PC_A = 32'h0000_1040;
    localparam logic [ADDR_W-1:0] PC_B = PC_A ^ 32'h0000_0044; // same fold as PC_A
    localparam logic [ADDR_W-1:0] PC_C = 32'h0000_2008;

    logic [ADDR_W-1:0] pool [8];

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        pool[0] = PC_A; pool[1] = PC_B; pool[2] = PC_C; pool[3] = 32'h8000_0000;
        pool[4] = 32'h0000_0ffc; pool[5] = 32'h1234_5678; pool[6] = 32'h0000_0004; pool[7] = 32'hdead_beec;

        do_reset();
        // R1: fresh state predicts not taken everywhere, history zero
        for (int i = 0; i < 4; i++) cycle("R1", 1'b0, pool[i], 1'b0, '0, 1'b0, '0, 1'b0);

        // R3: walk counter up to saturation, back down to saturation, then up once
        for (int i = 0; i < 4; i++) cycle("R3", 1'b0, PC_A, 1'b1, PC_A, 1'b1, '0, 1'b0);
        for (int i = 0; i < 5; i++) cycle("R3", 1'b0, PC_A, 1'b1, PC_A, 1'b0, '0, 1'b0);
        cycle("R3", 1'b0, PC_A, 1'b1, PC_A, 1'b1, '0, 1'b0);
        cycle("R3", 1'b0, PC_A, 1'b0, '0, 1'b0, '0, 1'b0);

        // R4: alias and alignment bits share the trained counter
        cycle("R4", 1'b0, PC_A, 1'b1, PC_A, 1'b1, '0, 1'b0);
        cycle("R4", 1'b0, PC_B, 1'b0, '0, 1'b0, '0, 1'b0);
        cycle("R4", 1'b0, PC_A | 32'h3, 1'b0, '0, 1'b0, '0, 1'b0);
        cycle("R4", 1'b0, PC_C, 1'b0, '0, 1'b0, '0, 1'b0);

        // R9: same-entry update and lookup see the old value
        cycle("R9", 1'b0, PC_A, 1'b1, PC_B, 1'b0, '0, 1'b0);
        cycle("R9", 1'b0, PC_A, 1'b0, '0, 1'b0, '0, 1'b0);

        // R5/R6/R8: predictions shift history but never train
        for (int i = 0; i < 6; i++) cycle("R5", 1'b1, PC_A, 1'b0, '0, 1'b0, '0, 1'b0);
        cycle("R8", 1'b0, PC_A, 1'b0, '0, 1'b0, '0, 1'b0);

        // R7: rewind beats a same-cycle prediction
        cycle("R7", 1'b1, PC_C, 1'b1, PC_C, 1'b1, 4'b1010, 1'b1);
        cycle("R7", 1'b0, PC_C, 1'b0, '0, 1'b0, '0, 1'b0);

        // R10: correct-path update leaves history alone
        cycle("R10", 1'b0, PC_A, 1'b1, PC_A, 1'b0, 4'b0110, 1'b0);
        cycle("R10", 1'b0, PC_A, 1'b0, '0, 1'b0, '0, 1'b0);

        // R2/R5/R7/R9: random mix against the model
        for (int i = 0; i < 4000; i++) begin
            cycle("R2", 1'($urandom), pool[$urandom % 8],
                  ($urandom % 3) != 0, pool[$urandom % 8], 1'($urandom),
                  HIST_W'($urandom), ($urandom % 5) == 0);
        end

        // R1: a second reset discards all trained state
        do_reset();
        for (int i = 0; i < 8; i++) cycle("R1", 1'b0, pool[i], 1'b0, '0, 1'b0, '0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule